// File: doc/BRIEF.md
# Dual-Port Configuration Pin Latch and Decoder

This block sits beside a two-port Ethernet transceiver. It reads the configuration pins while the chip is held in reset, and it keeps those levels fixed once reset goes away. Each pin level first passes through a two-flop synchroniser. A capture register follows the synchronised levels for as long as the internally synchronised reset is low. It freezes on the clock edge where that reset is released.

From the frozen pin image the block derives each port's settings. These are the station address, whether auto-negotiation runs, the forced speed and duplex or else the ability set offered to the partner, and the MAC-side interface style. It also derives the crossover-detection enable, the low-power wake-on-energy enable, the LED scheme and the reference-clock output enable. A single error flag reports strap combinations that cannot work together. When that flag is raised, every port's interface falls back to plain MII.

Top module: `phy_strap_cfg`

## Requirements
- R1: After reset has been released and synchronised, later changes on any strap pin leave every output unchanged until reset is asserted again.
- R2: Port p's 5-bit address is {strap_addr_hi, p}: bits [4:1] come from the shared pins, and bit 0 is 0 for port 0 and 1 for port 1.
- R3: With strap_aneg[p]=0, force_100[p]=strap_ansel[2p+1] and force_fdx[p]=strap_ansel[2p], aneg_en[p]=0 and adv_abil for the port is 0.
- R4: With strap_aneg[p]=1, aneg_en[p]=1, the force bits are 0, and adv_abil[4p+3:4p] = {100 full, 100 half, 10 full, 10 half}. The value is 4'b0011 for select 00, 4'b1100 for 01, 4'b0101 for 10 and 4'b1111 for 11 (select = {AN1, AN0} = strap_ansel[2p+1:2p]).
- R5: Without extender mode and without error, mac_mode[2p+1:2p] is 0 (MII) when strap_mii[p]=0, 1 (RMII) when strap_mii[p]=1 and strap_sni[p]=0, and 2 (serial 10 Mb/s) when both are 1.
- R6: With strap_ext=1 and no error, a port with strap_mii[p]=0 reports 3 (single-clock MII), and an RMII port stays at 1.
- R7: strap_ext=1 together with any port strapped for serial mode (strap_mii and strap_sni both 1) raises cfg_err and forces every mac_mode field to 0.
- R8: Ports that disagree on RMII selection raise cfg_err and force every mac_mode field to 0.
- R9: mdix_en[p]=strap_mdix[p], edet_en[p]=strap_edet[p], led_alt[p]=NOT strap_led[p], clkout_en=NOT strap_clkdis. The idle pin levels (ansel 1s, aneg 1, mdix 1, edet 0, led 1, clkdis 0, mii 0) give auto-negotiation with all four abilities, crossover on, energy detect off, LED scheme 1, clock out on, and MII.
- R10: While rst_n is held low with stable pins for at least three clocks, the outputs show the decode of the present pin levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| strap_addr_hi | input | 4 | Shared address pins, address bits [4:1] |
| strap_aneg | input | 2 | Per-port auto-negotiation enable pin |
| strap_ansel | input | 4 | Per-port {AN1,AN0} pair, port p at [2p+1:2p] |
| strap_mii | input | 2 | Per-port reduced-interface select pin |
| strap_sni | input | 2 | Per-port serial-mode select pin |
| strap_mdix | input | 2 | Per-port crossover-detect enable pin |
| strap_edet | input | 2 | Per-port energy-detect enable pin |
| strap_led | input | 2 | Per-port LED scheme pin (1 = scheme 1) |
| strap_clkdis | input | 1 | Reference clock output disable pin |
| strap_ext | input | 1 | Extender mode pin, shared |
| port_addr | output | 10 | Per-port 5-bit address, port p at [5p+4:5p] |
| aneg_en | output | 2 | Auto-negotiation enabled per port |
| force_100 | output | 2 | Forced 100 Mb/s per port |
| force_fdx | output | 2 | Forced full duplex per port |
| adv_abil | output | 8 | Per-port advertised ability nibble |
| mac_mode | output | 4 | Per-port interface code: 0 MII, 1 RMII, 2 serial, 3 single-clock MII |
| mdix_en | output | 2 | Crossover detection enabled per port |
| edet_en | output | 2 | Energy detect enabled per port |
| led_alt | output | 2 | LED scheme 2 selected per port |
| clkout_en | output | 1 | Reference clock output enabled |
| cfg_err | output | 1 | Illegal strap combination |

## Verification
The hold check assumes that rst_n stays high for at least three clocks before the outputs are considered frozen. The bench therefore always releases reset on a falling clock edge and waits four clocks before it judges or disturbs the pins. The mode checks assume that pin levels are steady for three clocks before a decode is read. In every run the stimulus sets all pins together and keeps them fixed through the whole reset window and the release. The sweeps cover every auto-negotiation pin pattern with a shifting address, and every combination of interface-select and extender pins.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int NPORT = 2;
  localparam int ABIL_W = 4;

  typedef enum logic [1:0] {
    MAC_MII   = 2'd0,
    MAC_RMII  = 2'd1,
    MAC_SER   = 2'd2,
    MAC_SCMII = 2'd3
  } mac_mode_e;

  // ability nibble: {100F, 100H, 10F, 10H}
  function automatic logic [ABIL_W-1:0] adv_of(input logic [1:0] sel);
    logic [ABIL_W-1:0] r;
    case (sel)
      2'b00:   r = 4'b0011;
      2'b01:   r = 4'b1100;
      2'b10:   r = 4'b0101;
      default: r = 4'b1111;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/strap_sync.sv
// Two-flop level synchroniser; data flops carry no reset so that pin
// levels keep flowing while the chip is held in reset.
module strap_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk) begin
    s1_q <= din;
    s2_q <= s1_q;
  end

  assign dout = s2_q;
endmodule

// File: rtl/strap_rst_sync.sv
module strap_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic r1_q, r2_q;
  logic r1_d, r2_d;

  always_comb begin
    r1_d = 1'b1;
    r2_d = r1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r1_q <= 1'b0;
      r2_q <= 1'b0;
    end else begin
      r1_q <= r1_d;
      r2_q <= r2_d;
    end
  end

  assign rst_sync_n = r2_q;
endmodule

// File: rtl/strap_port_dec.sv
module strap_port_dec
  import strap_pkg::*;
(
  input  logic              aneg_pin,
  input  logic [1:0]        ansel_pin,
  input  logic              mii_pin,
  input  logic              sni_pin,
  input  logic              ext_pin,
  input  logic              glob_err,
  output logic              aneg_en,
  output logic              force_100,
  output logic              force_fdx,
  output logic [ABIL_W-1:0] adv,
  output mac_mode_e         mode
);
  always_comb begin
    aneg_en   = aneg_pin;
    force_100 = 1'b0;
    force_fdx = 1'b0;
    adv       = '0;
    if (aneg_pin) begin
      adv = adv_of(ansel_pin);
    end else begin
      force_100 = ansel_pin[1];
      force_fdx = ansel_pin[0];
    end
  end

  always_comb begin
    if (glob_err)      mode = MAC_MII;
    else if (!mii_pin) mode = ext_pin ? MAC_SCMII : MAC_MII;
    else if (sni_pin)  mode = MAC_SER;
    else               mode = MAC_RMII;
  end
endmodule

// File: rtl/phy_strap_cfg.sv
module phy_strap_cfg
  import strap_pkg::*;
#(
  parameter int ADDR_HI_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_HI_W-1:0]       strap_addr_hi,
  input  logic [NPORT-1:0]           strap_aneg,
  input  logic [2*NPORT-1:0]         strap_ansel,
  input  logic [NPORT-1:0]           strap_mii,
  input  logic [NPORT-1:0]           strap_sni,
  input  logic [NPORT-1:0]           strap_mdix,
  input  logic [NPORT-1:0]           strap_edet,
  input  logic [NPORT-1:0]           strap_led,
  input  logic                       strap_clkdis,
  input  logic                       strap_ext,
  output logic [(ADDR_HI_W+1)*NPORT-1:0] port_addr,
  output logic [NPORT-1:0]           aneg_en,
  output logic [NPORT-1:0]           force_100,
  output logic [NPORT-1:0]           force_fdx,
  output logic [ABIL_W*NPORT-1:0]    adv_abil,
  output logic [2*NPORT-1:0]         mac_mode,
  output logic [NPORT-1:0]           mdix_en,
  output logic [NPORT-1:0]           edet_en,
  output logic [NPORT-1:0]           led_alt,
  output logic                       clkout_en,
  output logic                       cfg_err
);
  localparam int AW     = ADDR_HI_W + 1;
  localparam int O_ADDR = 0;
  localparam int O_ANEG = O_ADDR + ADDR_HI_W;
  localparam int O_SEL  = O_ANEG + NPORT;
  localparam int O_MII  = O_SEL + 2*NPORT;
  localparam int O_SNI  = O_MII + NPORT;
  localparam int O_MDIX = O_SNI + NPORT;
  localparam int O_EDET = O_MDIX + NPORT;
  localparam int O_LED  = O_EDET + NPORT;
  localparam int O_CDIS = O_LED + NPORT;
  localparam int O_EXT  = O_CDIS + 1;
  localparam int RAW_W  = O_EXT + 1;

  logic [RAW_W-1:0] raw, raw_sync;
  logic [RAW_W-1:0] cap_q, cap_d;
  logic             rst_sync_n;
  logic             cap_en;

  assign raw = {strap_ext, strap_clkdis, strap_led, strap_edet, strap_mdix,
                strap_sni, strap_mii, strap_ansel, strap_aneg, strap_addr_hi};

  strap_sync #(.W(RAW_W)) u_sync (.clk(clk), .din(raw), .dout(raw_sync));
  strap_rst_sync u_rsync (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  // capture window: open while the synchronised reset is low
  assign cap_en = ~rst_sync_n;

  always_comb begin
    cap_d = cap_q;
    if (cap_en) cap_d = raw_sync;
  end

  always_ff @(posedge clk) begin
    cap_q <= cap_d;
  end

  logic [ADDR_HI_W-1:0] c_addr;
  logic [NPORT-1:0]     c_aneg, c_mii, c_sni, c_mdix, c_edet, c_led;
  logic [2*NPORT-1:0]   c_sel;
  logic                 c_cdis, c_ext;

  assign c_addr = cap_q[O_ANEG-1:O_ADDR];
  assign c_aneg = cap_q[O_SEL-1:O_ANEG];
  assign c_sel  = cap_q[O_MII-1:O_SEL];
  assign c_mii  = cap_q[O_SNI-1:O_MII];
  assign c_sni  = cap_q[O_MDIX-1:O_SNI];
  assign c_mdix = cap_q[O_EDET-1:O_MDIX];
  assign c_edet = cap_q[O_LED-1:O_EDET];
  assign c_led  = cap_q[O_CDIS-1:O_LED];
  assign c_cdis = cap_q[O_CDIS];
  assign c_ext  = cap_q[O_EXT];

  logic [NPORT-1:0] is_rmii, is_ser;
  logic             ext_conflict, rmii_split;

  assign is_rmii      = c_mii & ~c_sni;
  assign is_ser       = c_mii & c_sni;
  assign ext_conflict = c_ext & (|is_ser);
  assign rmii_split   = (|is_rmii) & ~(&is_rmii);
  assign cfg_err      = ext_conflict | rmii_split;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    mac_mode_e mode_p;
    strap_port_dec u_dec (
      .aneg_pin  (c_aneg[p]),
      .ansel_pin (c_sel[2*p+1 -: 2]),
      .mii_pin   (c_mii[p]),
      .sni_pin   (c_sni[p]),
      .ext_pin   (c_ext),
      .glob_err  (cfg_err),
      .aneg_en   (aneg_en[p]),
      .force_100 (force_100[p]),
      .force_fdx (force_fdx[p]),
      .adv       (adv_abil[ABIL_W*p +: ABIL_W]),
      .mode      (mode_p)
    );
    assign mac_mode[2*p +: 2]  = mode_p;
    assign port_addr[AW*p +: AW] = {c_addr, 1'(p)};
  end

  assign mdix_en   = c_mdix;
  assign edet_en   = c_edet;
  assign led_alt   = ~c_led;
  assign clkout_en = ~c_cdis;
endmodule

// File: rtl/strap_cfg_chk.sv
module strap_cfg_chk
  import strap_pkg::*;
#(
  parameter int ADDR_HI_W = 4
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [(ADDR_HI_W+1)*NPORT-1:0] port_addr,
  input logic [NPORT-1:0]               aneg_en,
  input logic [NPORT-1:0]               force_100,
  input logic [NPORT-1:0]               force_fdx,
  input logic [ABIL_W*NPORT-1:0]        adv_abil,
  input logic [2*NPORT-1:0]             mac_mode,
  input logic                           cfg_err
);
  logic [NPORT-1:0] rmii_ports;
  for (genvar p = 0; p < NPORT; p++) begin : g_rm
    assign rmii_ports[p] = (mac_mode[2*p +: 2] == 2'd1);
  end

  // R1: frozen outputs once reset has been high for three clocks
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rst_n, 2) && $past(rst_n, 3)) |->
      ($stable(port_addr) && $stable(aneg_en) && $stable(adv_abil) &&
       $stable(mac_mode) && $stable(cfg_err)));

  // R7 / R8: on error every port reports plain MII
  a_r7_err_mii: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (mac_mode == '0));

  // R8: without error the ports agree on RMII
  a_r8_rmii_agree: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_err |-> ($countones(rmii_ports) == 0 || $countones(rmii_ports) == NPORT));

  for (genvar p = 0; p < NPORT; p++) begin : g_p
    // R3: forced ports advertise nothing
    a_r3_forced_noadv: assert property (@(posedge clk) disable iff (!rst_n)
      !aneg_en[p] |-> (adv_abil[ABIL_W*p +: ABIL_W] == '0));
    // R4: negotiating ports force nothing and always offer a half-duplex ability
    a_r4_aneg_nofrc: assert property (@(posedge clk) disable iff (!rst_n)
      aneg_en[p] |-> (!force_100[p] && !force_fdx[p] &&
                      (adv_abil[ABIL_W*p] || adv_abil[ABIL_W*p+2])));
  end
endmodule

bind phy_strap_cfg strap_cfg_chk #(.ADDR_HI_W(ADDR_HI_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .port_addr (port_addr),
  .aneg_en   (aneg_en),
  .force_100 (force_100),
  .force_fdx (force_fdx),
  .adv_abil  (adv_abil),
  .mac_mode  (mac_mode),
  .cfg_err   (cfg_err)
);

// File: tb/sim_phy_strap_cfg.sv
`timescale 1ns/1ps
module sim_phy_strap_cfg;
  logic clk = 1'b0;
  logic rst_n;
  logic [3:0] s_addr;
  logic [1:0] s_aneg, s_mii, s_sni, s_mdix, s_edet, s_led;
  logic [3:0] s_sel;
  logic       s_cdis, s_ext;

  logic [9:0] port_addr;
  logic [1:0] aneg_en, force_100, force_fdx, mdix_en, edet_en, led_alt;
  logic [7:0] adv_abil;
  logic [3:0] mac_mode;
  logic       clkout_en, cfg_err;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  phy_strap_cfg u0 (
    .clk(clk), .rst_n(rst_n),
    .strap_addr_hi(s_addr), .strap_aneg(s_aneg), .strap_ansel(s_sel),
    .strap_mii(s_mii), .strap_sni(s_sni), .strap_mdix(s_mdix),
    .strap_edet(s_edet), .strap_led(s_led), .strap_clkdis(s_cdis),
    .strap_ext(s_ext),
    .port_addr(port_addr), .aneg_en(aneg_en), .force_100(force_100),
    .force_fdx(force_fdx), .adv_abil(adv_abil), .mac_mode(mac_mode),
    .mdix_en(mdix_en), .edet_en(edet_en), .led_alt(led_alt),
    .clkout_en(clkout_en), .cfg_err(cfg_err)
  );

  // expected values, held across a run
  logic [9:0] e_addr;
  logic [1:0] e_aneg, e_f100, e_ffdx, e_mdix, e_edet, e_led;
  logic [7:0] e_adv;
  logic [3:0] e_mode;
  logic       e_clk, e_err;
  string      mode_tag;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, exp);
    end
  endtask

  task automatic compute();
    logic [1:0] rm, ser;
    logic ext_bad, split;
    for (int p = 0; p < 2; p++) begin
      e_addr[5*p +: 5] = {s_addr, p[0]};
      e_aneg[p] = s_aneg[p];
      if (s_aneg[p]) begin
        e_f100[p] = 1'b0; e_ffdx[p] = 1'b0;
        // nibble {100F,100H,10F,10H}
        e_adv[4*p +: 4] = {s_sel[2*p] | s_sel[2*p+1] ? 1'b1 : 1'b0, 1'b0, 1'b0, 1'b0};
        case (s_sel[2*p +: 2])
          2'b00: e_adv[4*p +: 4] = 4'b0011;
          2'b01: e_adv[4*p +: 4] = 4'b1100;
          2'b10: e_adv[4*p +: 4] = 4'b0101;
          default: e_adv[4*p +: 4] = 4'b1111;
        endcase
      end else begin
        e_f100[p] = s_sel[2*p+1];
        e_ffdx[p] = s_sel[2*p];
        e_adv[4*p +: 4] = 4'b0000;
      end
      rm[p]  = s_mii[p] & ~s_sni[p];
      ser[p] = s_mii[p] & s_sni[p];
    end
    ext_bad = s_ext && (ser != 2'b00);
    split   = (rm == 2'b01) || (rm == 2'b10);
    e_err   = ext_bad || split;
    if (ext_bad)     mode_tag = "R7";
    else if (split)  mode_tag = "R8";
    else if (s_ext)  mode_tag = "R6";
    else             mode_tag = "R5";
    for (int p = 0; p < 2; p++) begin
      if (e_err)           e_mode[2*p +: 2] = 2'd0;
      else if (!s_mii[p])  e_mode[2*p +: 2] = s_ext ? 2'd3 : 2'd0;
      else if (s_sni[p])   e_mode[2*p +: 2] = 2'd2;
      else                 e_mode[2*p +: 2] = 2'd1;
    end
    e_mdix = s_mdix;
    e_edet = s_edet;
    e_led  = ~s_led;
    e_clk  = ~s_cdis;
  endtask

  task automatic check_all(input string over);
    string t2, t3, t4, t9, tm, te;
    t2 = (over == "") ? "R2" : over;
    t3 = (over == "") ? "R3" : over;
    t4 = (over == "") ? "R4" : over;
    t9 = (over == "") ? "R9" : over;
    tm = (over == "") ? mode_tag : over;
    te = (over == "") ? mode_tag : over;
    chk(t2, "port_addr", 32'(port_addr), 32'(e_addr));
    chk(t3, "force_100", 32'(force_100), 32'(e_f100));
    chk(t3, "force_fdx", 32'(force_fdx), 32'(e_ffdx));
    chk(t4, "aneg_en", 32'(aneg_en), 32'(e_aneg));
    chk(t4, "adv_abil", 32'(adv_abil), 32'(e_adv));
    chk(tm, "mac_mode", 32'(mac_mode), 32'(e_mode));
    chk(te, "cfg_err", 32'(cfg_err), 32'(e_err));
    chk(t9, "mdix_en", 32'(mdix_en), 32'(e_mdix));
    chk(t9, "edet_en", 32'(edet_en), 32'(e_edet));
    chk(t9, "led_alt", 32'(led_alt), 32'(e_led));
    chk(t9, "clkout_en", 32'(clkout_en), 32'(e_clk));
  endtask

  // one reset cycle with the current pin image
  task automatic run_one();
    @(negedge clk);
    rst_n = 1'b0;
    compute();
    repeat (4) @(negedge clk);
    check_all("R10");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("");
    // disturb every pin after release: R1
    s_addr = ~s_addr; s_aneg = ~s_aneg; s_sel = ~s_sel; s_mii = ~s_mii;
    s_sni = ~s_sni; s_mdix = ~s_mdix; s_edet = ~s_edet; s_led = ~s_led;
    s_cdis = ~s_cdis; s_ext = ~s_ext;
    repeat (6) @(negedge clk);
    check_all("R1");
  endtask

  task automatic defaults();
    s_addr = 4'h0; s_aneg = 2'b11; s_sel = 4'b1111; s_mii = 2'b00;
    s_sni = 2'b00; s_mdix = 2'b11; s_edet = 2'b00; s_led = 2'b11;
    s_cdis = 1'b0; s_ext = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    defaults();
    // R9: idle pin levels
    run_one();
    // R2/R3/R4: every auto-negotiation pin pattern, sliding address
    for (int i = 0; i < 64; i++) begin
      defaults();
      s_aneg = i[1:0];
      s_sel  = i[5:2];
      s_addr = 4'(i) ^ 4'(i >> 4);
      run_one();
    end
    // R5..R9: every interface-select and extender pattern
    for (int j = 0; j < 32; j++) begin
      defaults();
      s_mii  = j[1:0];
      s_sni  = j[3:2];
      s_ext  = j[4];
      s_mdix = j[2:1];
      s_edet = j[1:0] ^ j[3:2];
      s_led  = ~j[3:2];
      s_cdis = j[0];
      run_one();
    end
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule